// File: doc/BRIEF.md
# Narrowing Right-Shift Instruction Decoder

This block is a purely combinational decoder for 32-bit instruction words of the two-register-and-shift class. It recognises the four narrowing right-shift operations. These are the plain and rounding truncating shifts, and the plain and rounding shifts that saturate from signed to unsigned. For a recognised word it reports the source element size, the right-shift distance, the rounding and saturation selects, and both 5-bit register indices. It also flags the word as undefined when its register operands are illegal.

The decoder sits beside an instruction-decode stage. The stage presents a word on `insn_i` and reads every output in the same cycle. A feature pin, `ext_regs_i`, tells the decoder whether the upper half of the register file (indices 16 to 31) exists. The block has no clock, no state and no flow control. There is no data stream, so no valid/ready handshake applies. Executing the shift is left to the datapath.

Top module: `nrw_shift_decode`

## Requirements
- R1: `valid_o` is 1 only when all of the following hold: bits [31:25] equal 1111001, bit 23 is 1, bits [11:8] equal 1000, bit 7 is 0, bit 4 is 1, and at least one of bits [21:19] is 1. Changing any one of those fixed bits clears `valid_o`.
- R2: When bits [21:19] are all 0, `valid_o` is 0 whatever the other bits are.
- R3: `size_o` encodes the source element width from the leading one of the immediate bits [21:16]. 1xxxxx gives 3 (64-bit), 01xxxx gives 2 (32-bit), and 001xxx gives 1 (16-bit).
- R4: `shamt_o` equals 32 − bits[20:16] for size 3, 16 − bits[19:16] for size 2, and 8 − bits[18:16] for size 1. Its range is therefore 1..32, 1..16 and 1..8 respectively.
- R5: `round_o` equals instruction bit 6, where 1 selects rounding.
- R6: `satu_o` equals instruction bit 24, where 1 selects the signed-to-unsigned saturating variants.
- R7: `rm_o` is {bit 5, bits [3:0]} and `rd_o` is {bit 22, bits [15:12]}.
- R8: A valid word with an odd `rm_o` raises `undef_o`.
- R9: When `ext_regs_i` is 0, a valid word with `rd_o` or `rm_o` at 16 or above raises `undef_o`. When `ext_regs_i` is 1, register indices never raise `undef_o`.
- R10: When `valid_o` is 0, every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word under decode |
| ext_regs_i | input | 1 | 1 when register indices 16..31 exist |
| valid_o | output | 1 | Word is a narrowing right shift |
| undef_o | output | 1 | Recognised word has illegal operands |
| size_o | output | 2 | Source element size code (1, 2, 3) |
| shamt_o | output | 6 | Right-shift distance |
| round_o | output | 1 | Rounding variant select |
| satu_o | output | 1 | Signed-to-unsigned saturating variant select |
| rd_o | output | 5 | Destination register index |
| rm_o | output | 5 | Source register index |

## Verification
The decoder holds no state, so any fault appears at the ports in the same evaluation as the word that exposes it. The bench sweeps every immediate value with every operation select, every source index, a spread of destination indices and both feature settings. This covers every leading-one position and every shift-distance boundary. A fault in leading-one selection shows as a wrong size together with a shift distance outside its range. A fault in the legality logic shows as a wrong `undef_o` on an odd or upper-half index. The sweep also flips each fixed opcode bit in turn, to show that near-miss words are rejected with all outputs at zero.

// File: rtl/nrw_pkg.sv
package nrw_pkg;
  localparam int INSN_W = 32;
  localparam int IDX_W  = 5;
  localparam int IMM_W  = 6;
  localparam int IMM_LO = 16;
  localparam int NUM_SZ = IMM_W - 3;
  localparam int SZ_W   = $clog2(NUM_SZ + 1);

  // fixed opcode bits: mask and value
  localparam logic [INSN_W-1:0] FIX_MASK = 32'hFE800F90;
  localparam logic [INSN_W-1:0] FIX_VAL  = 32'hF2800810;

  localparam int B_SATU  = 24;
  localparam int B_ROUND = 6;
  localparam int B_RDHI  = 22;
  localparam int B_RMHI  = 5;
  localparam int RD_LO   = 12;
  localparam int RM_LO   = 0;

  typedef enum logic [SZ_W-1:0] {
    SRC_NONE = 2'd0,
    SRC_H    = 2'd1,
    SRC_S    = 2'd2,
    SRC_D    = 2'd3
  } src_size_e;
endpackage

// File: rtl/nrw_match.sv
module nrw_match
  import nrw_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output logic              hit_o
);
  assign hit_o = (insn_i & FIX_MASK) == FIX_VAL;
endmodule

// File: rtl/nrw_imm_decode.sv
module nrw_imm_decode
  import nrw_pkg::*;
(
  input  logic [IMM_W-1:0] imm_i,
  output logic [SZ_W-1:0]  size_o,
  output logic [IMM_W-1:0] shamt_o
);
  logic [NUM_SZ-1:0] sel;
  logic [IMM_W-1:0]  amt [NUM_SZ];

  // level g: leading one at bit 3+g, lower bits carry the encoded distance
  for (genvar g = 0; g < NUM_SZ; g++) begin : g_lvl
    localparam int FW = 3 + g;
    assign sel[g] = imm_i[FW] && ((imm_i >> (FW + 1)) == '0);
    assign amt[g] = (IMM_W'(1) << FW) - IMM_W'(imm_i[FW-1:0]);
  end

  always_comb begin
    size_o  = '0;
    shamt_o = '0;
    for (int g = 0; g < NUM_SZ; g++) begin
      if (sel[g]) begin
        size_o  = SZ_W'(g + 1);
        shamt_o = amt[g];
      end
    end
  end

  always_comb begin
    a_r3_one_level: assert ($onehot0(sel)) else $error("R3 several size levels selected");
    if (size_o != '0) begin
      a_r4_amt_nonzero: assert (shamt_o != '0) else $error("R4 zero shift distance");
      a_r4_amt_bound: assert (shamt_o <= (IMM_W'(1) << (size_o + 2))) else $error("R4 distance beyond element");
    end
  end
endmodule

// File: rtl/nrw_legal.sv
module nrw_legal
  import nrw_pkg::*;
(
  input  logic             valid_i,
  input  logic             ext_regs_i,
  input  logic [IDX_W-1:0] rd_i,
  input  logic [IDX_W-1:0] rm_i,
  output logic             undef_o
);
  logic odd_src, upper_use;
  assign odd_src   = rm_i[0];
  assign upper_use = rd_i[IDX_W-1] | rm_i[IDX_W-1];
  assign undef_o   = valid_i & (odd_src | (~ext_regs_i & upper_use));
endmodule

// File: rtl/nrw_shift_decode.sv
module nrw_shift_decode
  import nrw_pkg::*;
(
  input  logic [31:0] insn_i,
  input  logic        ext_regs_i,
  output logic        valid_o,
  output logic        undef_o,
  output logic [1:0]  size_o,
  output logic [5:0]  shamt_o,
  output logic        round_o,
  output logic        satu_o,
  output logic [4:0]  rd_o,
  output logic [4:0]  rm_o
);
  logic             hit;
  logic [SZ_W-1:0]  size_raw;
  logic [IMM_W-1:0] shamt_raw;
  logic [IDX_W-1:0] rd_raw, rm_raw;
  logic             undef_raw;

  nrw_match u_match (
    .insn_i (insn_i),
    .hit_o  (hit)
  );

  nrw_imm_decode u_imm (
    .imm_i   (insn_i[IMM_LO +: IMM_W]),
    .size_o  (size_raw),
    .shamt_o (shamt_raw)
  );

  assign rd_raw = {insn_i[B_RDHI], insn_i[RD_LO +: IDX_W-1]};
  assign rm_raw = {insn_i[B_RMHI], insn_i[RM_LO +: IDX_W-1]};

  assign valid_o = hit && (size_raw != SZ_W'(SRC_NONE));

  nrw_legal u_legal (
    .valid_i    (valid_o),
    .ext_regs_i (ext_regs_i),
    .rd_i       (rd_raw),
    .rm_i       (rm_raw),
    .undef_o    (undef_raw)
  );

  // every field is forced to zero for an unrecognised word
  assign undef_o = undef_raw;
  assign size_o  = valid_o ? size_raw  : '0;
  assign shamt_o = valid_o ? shamt_raw : '0;
  assign round_o = valid_o & insn_i[B_ROUND];
  assign satu_o  = valid_o & insn_i[B_SATU];
  assign rd_o    = valid_o ? rd_raw : '0;
  assign rm_o    = valid_o ? rm_raw : '0;

  always_comb begin
    a_r10_undef_needs_valid: assert (!undef_o || valid_o) else $error("R10 undef without valid");
    if (valid_o && !undef_o) begin
      a_r8_even_source: assert (!rm_o[0]) else $error("R8 odd source accepted");
      if (!ext_regs_i) begin
        a_r9_low_bank: assert (!rd_o[IDX_W-1] && !rm_o[IDX_W-1]) else $error("R9 upper index accepted");
      end
    end
    if (valid_o) begin
      a_r3_size_known: assert (size_o != 2'd0) else $error("R3 valid word without size");
    end
  end
endmodule

// File: tb/nrw_shift_decode_tb.sv
module nrw_shift_decode_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;
  localparam logic [31:0] BASE = 32'hF2800810;

  logic        clk = 1'b0;
  logic [31:0] insn = '0;
  logic        ext = 1'b0;
  logic        valid, undef, round, satu;
  logic [1:0]  size;
  logic [5:0]  shamt;
  logic [4:0]  rd, rm;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nrw_shift_decode u_dut (
    .insn_i(insn), .ext_regs_i(ext), .valid_o(valid), .undef_o(undef),
    .size_o(size), .shamt_o(shamt), .round_o(round), .satu_o(satu),
    .rd_o(rd), .rm_o(rm)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s insn=%08h ext=%0d act=%0d exp=%0d", req, insn, ext, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit sat, input bit rnd, input int imm,
                                     input int d, input int m);
    logic [31:0] w = BASE;
    w[24] = sat; w[6] = rnd; w[21:16] = imm[5:0];
    w[22] = d[4]; w[15:12] = d[3:0];
    w[5] = m[4]; w[3:0] = m[3:0];
    return w;
  endfunction

  task automatic check_zero(input string req);
    chk(req, {valid, undef, round, satu}, 0);
    chk(req, {size, shamt, rd, rm}, 0);
  endtask

  task automatic check_word(input bit sat, input bit rnd, input int imm,
                            input int d, input int m);
    int esz, esh;
    bit eund;
    if (imm >= 32)      begin esz = 3; esh = 32 - (imm % 32); end
    else if (imm >= 16) begin esz = 2; esh = 16 - (imm % 16); end
    else if (imm >= 8)  begin esz = 1; esh = 8 - (imm % 8); end
    else                begin esz = 0; esh = 0; end
    if (esz == 0) begin
      chk("R2", valid, 0);
      check_zero("R10");
    end else begin
      eund = (m % 2 == 1) || (!ext && (d >= 16 || m >= 16));
      chk("R1", valid, 1);
      chk("R3", size, esz);
      chk("R4", shamt, esh);
      chk("R5", round, rnd);
      chk("R6", satu, sat);
      chk("R7 rd", rd, d);
      chk("R7 rm", rm, m);
      chk((m % 2 == 1) ? "R8" : "R9", undef, eund);
    end
  endtask

  initial begin
    int dlist[5] = '{0, 7, 15, 16, 31};
    #1;
    check_zero("R10");                      // all-zero word at start
    for (int e = 0; e < 2; e++) begin
      for (int op = 0; op < 4; op++) begin
        for (int imm = 0; imm < 64; imm++) begin
          for (int di = 0; di < 5; di++) begin
            for (int m = 0; m < 32; m++) begin
              ext = e[0];
              insn = mk(op[1], op[0], imm, dlist[di], m);
              #1;
              check_word(op[1], op[0], imm, dlist[di], m);
            end
          end
        end
      end
    end
    // R1: flipping any single fixed opcode bit rejects the word
    for (int b = 0; b < 32; b++) begin
      if (b == 31 || b == 30 || b == 29 || b == 28 || b == 27 || b == 26 ||
          b == 25 || b == 23 || b == 11 || b == 10 || b == 9 || b == 8 ||
          b == 7 || b == 4) begin
        ext = 1'b1;
        insn = mk(1'b1, 1'b1, 40, 2, 4);
        insn[b] = ~insn[b];
        #1;
        chk("R1", valid, 0);
        check_zero("R10");
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule